// File: doc/BRIEF.md
# Peripheral Bus Clock Divider

This block turns a parent clock into a slower peripheral bus clock by an integer ratio between 1 and 128, with an enable gate on the output. Software uses one register. It polls a ready flag, writes a new ratio, and waits for ready to come back before it relies on the new rate.

A new ratio never takes effect in the middle of an output period. The divider finishes the period it is in, then switches. As a result, no output phase is ever shorter than the old or the new ratio allows. When software turns the enable off, the output finishes its current period and then stays low. A ratio of one passes the parent clock straight through.

Top module: `pbclk_div`

## Requirements
- R1: The divider field sits at bits 6:0 of the register and holds the ratio minus one. Values 0 to 127 select division by 1 to 128. At reset the field reads 0.
- R2: Bit 15 is the enable. When it is 0 the output is held low. It reads back as the last value written, and it is 0 at reset.
- R3: Bit 11 is a read-only ready flag. It is 1 at reset and whenever a new ratio can be accepted. It reads 0 from the cycle after an accepted ratio write until that ratio is in effect.
- R4: Once ready returns to 1, the divider field reads exactly the value that was written.
- R5: While the output runs, a new ratio takes effect only after the current output period ends. The period in progress keeps its old high and low lengths. While the output is stopped, a new ratio is applied on the next parent edge.
- R6: For a ratio N of 2 or more, each output period stays high for ceil(N/2) parent cycles and then low for floor(N/2) parent cycles.
- R7: With a ratio of 1 and the enable set, the output follows the parent clock.
- R8: A write made while ready is 0 leaves the divider field unchanged, and the pending ratio is still the one applied. The enable bit of such a write is still taken.
- R9: After the enable is cleared, the output completes its current period and then stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising parent edge |
| wr_data | input | 16 | Register write value |
| rd_data | output | 16 | Register read value: ratio field, ready flag and enable |
| clk_out | output | 1 | Divided and gated peripheral bus clock |
| ready | output | 1 | Same as the ready flag in the register |

## Verification
The bench sets a new ratio in the middle of a high phase and measures the rest of that period. A design that switched at once would cut the phase short or stretch it to the new length. A second write that lands while ready is low must be dropped. A design that accepted it would read back the wrong field and run at the wrong rate. The bench also checks the odd-ratio split, the 128 extreme and the pass-through at ratio one. These catch an off-by-one in the ratio encoding or in the high-phase length. Finally, it clears the enable in mid-period. A design that stopped at once would leave a runt high pulse, and one that never stopped would keep toggling.

// File: rtl/pbdiv_pkg.sv
package pbdiv_pkg;
   localparam int unsigned DEF_DIV_W   = 7;
   localparam int unsigned DEF_DATA_W  = 16;
   localparam int unsigned DEF_EN_POS  = 15;
   localparam int unsigned DEF_RDY_POS = 11;
   localparam int unsigned MAX_DIV_W   = 16;
endpackage

// File: rtl/pbdiv_regs.sv
module pbdiv_regs #(
   parameter int unsigned DIV_W   = pbdiv_pkg::DEF_DIV_W,
   parameter int unsigned DATA_W  = pbdiv_pkg::DEF_DATA_W,
   parameter int unsigned EN_POS  = pbdiv_pkg::DEF_EN_POS,
   parameter int unsigned RDY_POS = pbdiv_pkg::DEF_RDY_POS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              applied,
   output logic              en_o,
   output logic [DIV_W-1:0]  pend_o,
   output logic              busy_o,
   output logic [DATA_W-1:0] rd_data
);
   logic             en_q;
   logic             busy_q;
   logic [DIV_W-1:0] pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         busy_q <= 1'b0;
         pend_q <= '0;
      end else begin
         if (wr_en) en_q <= wr_data[EN_POS];
         if (wr_en && !busy_q) begin
            pend_q <= wr_data[DIV_W-1:0];
            busy_q <= 1'b1;
         end else if (applied) begin
            busy_q <= 1'b0;
         end
      end
   end

   always_comb begin
      rd_data              = '0;
      rd_data[DIV_W-1:0]   = pend_q;
      rd_data[RDY_POS]     = !busy_q;
      rd_data[EN_POS]      = en_q;
   end

   assign en_o   = en_q;
   assign pend_o = pend_q;
   assign busy_o = busy_q;

   // R8
   busy_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && wr_en) |=> $stable(pend_q));

   // R2
   enable_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (en_q == $past(wr_data[EN_POS])));
endmodule

// File: rtl/pbdiv_count.sv
module pbdiv_count #(
   parameter int unsigned DIV_W = pbdiv_pkg::DEF_DIV_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] pend,
   input  logic             busy,
   output logic             applied,
   output logic             div_q,
   output logic             running,
   output logic [DIV_W-1:0] act
);
   localparam int unsigned CW = DIV_W + 1;

   logic             run_q;
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] act_q;
   logic             bound;
   logic [DIV_W-1:0] act_nxt;
   logic [CW-1:0]    hi_cur;
   logic [CW-1:0]    cnt_inc;

   assign bound   = !run_q || (cnt_q == act_q);
   assign applied = busy && bound;
   assign act_nxt = applied ? pend : act_q;
   assign hi_cur  = ({1'b0, act_q} + CW'(2)) >> 1;
   assign cnt_inc = {1'b0, cnt_q} + CW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
         act_q <= '0;
         div_q <= 1'b0;
      end else begin
         act_q <= act_nxt;
         if (bound) begin
            cnt_q <= '0;
            run_q <= en;
            div_q <= en;
         end else begin
            cnt_q <= cnt_q + 1'b1;
            div_q <= (cnt_inc < hi_cur);
         end
      end
   end

   assign running = run_q;
   assign act     = act_q;

   // R1
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (cnt_q <= act_q));

   // R5
   ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && (cnt_q != act_q)) |=> $stable(act_q));

   // R9
   stay_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !en) |=> (!run_q && !div_q));

   // R4
   apply_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      applied |=> (act_q == $past(pend)));
endmodule

// File: rtl/pbdiv_gate.sv
module pbdiv_gate #(
   parameter int unsigned DIV_W      = pbdiv_pkg::DEF_DIV_W,
   parameter bit          BYPASS_ONE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] act,
   input  logic             div_q,
   output logic             clk_out
);
   generate
      if (BYPASS_ONE) begin : g_bypass
         logic gate_q;
         logic one_sel;
         assign one_sel = (act == '0);
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) gate_q <= 1'b0;
            else        gate_q <= run && one_sel;
         end
         assign clk_out = one_sel ? (clk & gate_q) : div_q;
      end else begin : g_plain
         assign clk_out = div_q;
      end
   endgenerate
endmodule

// File: rtl/pbclk_div.sv
module pbclk_div #(
   parameter int unsigned DIV_W      = pbdiv_pkg::DEF_DIV_W,
   parameter int unsigned DATA_W     = pbdiv_pkg::DEF_DATA_W,
   parameter int unsigned EN_POS     = pbdiv_pkg::DEF_EN_POS,
   parameter int unsigned RDY_POS    = pbdiv_pkg::DEF_RDY_POS,
   parameter bit          BYPASS_ONE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              clk_out,
   output logic              ready
);
   generate
      if (DIV_W < 1 || DIV_W > pbdiv_pkg::MAX_DIV_W) begin : g_bad_w
         $error("pbclk_div: DIV_W out of range");
      end
      if (EN_POS >= DATA_W || RDY_POS >= DATA_W) begin : g_bad_pos
         $error("pbclk_div: flag position beyond data width");
      end
      if (RDY_POS < DIV_W || EN_POS < DIV_W || EN_POS == RDY_POS) begin : g_bad_ovl
         $error("pbclk_div: register fields overlap");
      end
   endgenerate

   logic             en;
   logic [DIV_W-1:0] pend;
   logic             busy;
   logic             applied;
   logic             div_q;
   logic             running;
   logic [DIV_W-1:0] act;

   pbdiv_regs #(
      .DIV_W(DIV_W), .DATA_W(DATA_W), .EN_POS(EN_POS), .RDY_POS(RDY_POS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .applied(applied), .en_o(en), .pend_o(pend), .busy_o(busy),
      .rd_data(rd_data)
   );

   pbdiv_count #(.DIV_W(DIV_W)) u_count (
      .clk(clk), .rst_n(rst_n), .en(en), .pend(pend), .busy(busy),
      .applied(applied), .div_q(div_q), .running(running), .act(act)
   );

   pbdiv_gate #(.DIV_W(DIV_W), .BYPASS_ONE(BYPASS_ONE)) u_gate (
      .clk(clk), .rst_n(rst_n), .run(running), .act(act),
      .div_q(div_q), .clk_out(clk_out)
   );

   assign ready = !busy;

   // R3
   ready_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (pend == act));
endmodule

// File: tb/pbclk_div_bench.sv
module pbclk_div_bench;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        clk_out;
   logic        ready;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   pbclk_div u_pbclk_div (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .clk_out(clk_out), .ready(ready)
   );

   always #(PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(output logic s);
      @(posedge clk);
      #1;
      s = clk_out;
   endtask

   task automatic wr(input logic [15:0] d, output logic s);
      wr_en = 1'b1;
      wr_data = d;
      step(s);
      wr_en = 1'b0;
   endtask

   task automatic wait_ready(input string req);
      logic s;
      int n = 0;
      while (!rd_data[11] && n < 400) begin
         step(s);
         n++;
      end
      chk(rd_data[11] == 1'b1, req, int'(rd_data[11]), 1);
   endtask

   task automatic wait_rise(input string req);
      logic s;
      logic prev;
      int n = 0;
      prev = 1'b1;
      step(s);
      while (!(prev == 1'b0 && s == 1'b1) && n < 400) begin
         prev = s;
         step(s);
         n++;
      end
      chk(n < 400, req, n, 0);
   endtask

   // Called just after a sample that showed the first high cycle of a period.
   task automatic measure(input int hi0, output int hi, output int lo);
      logic s;
      hi = hi0;
      lo = 0;
      step(s);
      while (s && hi < 300) begin
         hi++;
         step(s);
      end
      lo = 1;
      step(s);
      while (!s && lo < 300) begin
         lo++;
         step(s);
      end
   endtask

   task automatic shape(input logic [15:0] d, input int ratio, input string req);
      logic s;
      int hi;
      int lo;
      wr(d, s);
      wait_ready(req);
      wait_rise(req);
      measure(1, hi, lo);
      chk(hi == (ratio + 1) / 2, req, hi, (ratio + 1) / 2);
      chk(lo == ratio / 2, req, lo, ratio / 2);
   endtask

   task automatic t_reset();
      logic s;
      chk(rd_data == 16'h0800, "R3 reset value", int'(rd_data), 16'h0800);
      for (int i = 0; i < 6; i++) begin
         step(s);
         chk(s == 1'b0, "R2 reset output low", int'(s), 0);
      end
   endtask

   task automatic t_handshake();
      logic s;
      wr(16'h0003, s);
      chk(rd_data[11] == 1'b0, "R3 ready drops after write", int'(rd_data[11]), 0);
      wait_ready("R3 ready returns");
      chk(rd_data[6:0] == 7'd3, "R4 field readback", int'(rd_data[6:0]), 3);
      chk(rd_data[15] == 1'b0, "R2 enable readback off", int'(rd_data[15]), 0);
   endtask

   task automatic t_even();
      shape(16'h8003, 4, "R1 ratio four");
      chk(rd_data[15] == 1'b1, "R2 enable readback on", int'(rd_data[15]), 1);
   endtask

   task automatic t_odd();
      shape(16'h8004, 5, "R6 odd ratio five");
   endtask

   task automatic t_max();
      shape(16'h807F, 128, "R1 ratio 128");
   endtask

   task automatic t_boundary();
      logic s;
      int hi;
      int lo;
      shape(16'h8007, 8, "R6 ratio eight");
      wait_rise("R5 sync");
      hi = 1;
      wr(16'h8001, s);
      if (s) hi++;
      wr(16'h8009, s);
      if (s) hi++;
      chk(rd_data[11] == 1'b0, "R8 busy during pending", int'(rd_data[11]), 0);
      while (s && hi < 300) begin
         step(s);
         if (s) hi++;
      end
      lo = 1;
      step(s);
      while (!s && lo < 300) begin
         lo++;
         step(s);
      end
      chk(hi == 4, "R5 old high phase kept", hi, 4);
      chk(lo == 4, "R5 old low phase kept", lo, 4);
      measure(1, hi, lo);
      chk(hi == 1 && lo == 1, "R5 new ratio two", hi * 10 + lo, 11);
      chk(rd_data[6:0] == 7'd1, "R8 ignored write", int'(rd_data[6:0]), 1);
      chk(rd_data[11] == 1'b1, "R4 ready after apply", int'(rd_data[11]), 1);
   endtask

   task automatic t_bypass();
      logic s;
      int ones = 0;
      wr(16'h8000, s);
      wait_ready("R7 ready");
      repeat (4) step(s);
      for (int i = 0; i < 10; i++) begin
         step(s);
         if (s) ones++;
      end
      chk(ones == 10, "R7 high with parent high", ones, 10);
      @(negedge clk);
      #1;
      chk(clk_out == 1'b0, "R7 low with parent low", int'(clk_out), 0);
   endtask

   task automatic t_disable();
      logic s;
      int hi;
      int stray = 0;
      shape(16'h8005, 6, "R6 ratio six");
      wait_rise("R9 sync");
      hi = 1;
      wr(16'h0005, s);
      if (s) hi++;
      while (s && hi < 300) begin
         step(s);
         if (s) hi++;
      end
      chk(hi == 3, "R9 high phase completes", hi, 3);
      for (int i = 0; i < 40; i++) begin
         step(s);
         if (s) stray++;
      end
      chk(stray == 0, "R9 output stays low", stray, 0);
      chk(rd_data[15] == 1'b0, "R2 enable cleared", int'(rd_data[15]), 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      t_reset();
      t_handshake();
      t_even();
      t_odd();
      t_max();
      t_boundary();
      t_bypass();
      t_disable();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
      end
      $finish;
   end

   initial begin
      #(PERIOD * 150000);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
      end
      $finish;
   end
endmodule